// File: doc/BRIEF.md
# Clock Synthesizer Configuration Register

This block holds the 8-bit configuration word of a clock synthesizer. The word has a multiplier field and a VCO range code. The block sits on a simple register bus with an address, a write strobe, write data and read data, and it decodes one offset, 0x0. Software programs the word while the synthesizer is not the selected system clock. While the synthesizer is selected, the block refuses writes and reports each refused write with a one-cycle error pulse.

Each accepted write clears the qualified lock status. The status comes back only after the raw lock input from the analog loop has stayed high for a programmable run of consecutive cycles.

A combinational checker takes the programmed multiplier, an oscillator frequency in whole MHz and a reference divider. From these it computes the VCO target frequency. It flags a mismatch when that frequency cannot be supported by the programmed range code, and it always flags the reserved code.

Top module: `pllcfg_top`

## Requirements
- R1: After reset, the stored word is 0x00, `lock_ok` is 0 and `wr_err` is 0. A read at offset 0 returns 0x00.
- R2: Bits [7:6] of the word are the VCO range code and bits [5:0] are the multiplier. A read returns the stored word at any time when `addr` is 0, in the same cycle. At any other address a read returns 0x00.
- R3: A write with `wr_en`=1, `addr`=0 and `pll_sel`=0 replaces the stored word with `wdata`. The new value is readable from the cycle after the write edge.
- R4: A write at offset 0 while `pll_sel`=1 leaves the stored word and `lock_ok` as they were. A write at any address other than 0 changes nothing and raises no error.
- R5: A write at offset 0 that is refused because `pll_sel`=1 drives `wr_err` high for exactly the cycle after the write edge. Back-to-back refused writes give back-to-back pulses.
- R6: An accepted write clears `lock_ok` at its edge and restarts the lock qualification count from zero.
- R7: `lock_ok` becomes 1 only after `lock_raw` has been sampled high on LOCK_CYC (default 16) consecutive edges that follow the last restart. A restart is an accepted write, reset, or `lock_raw` sampled low. A low sample also clears `lock_ok`.
- R8: The VCO frequency is the integer quotient floor(2·`osc_mhz`·(multiplier+1)/(`refdiv`+1)) in MHz. When it lies below 32 or above 120, `vco_mismatch` is 1.
- R9: `vco_mismatch` is 0 only when the frequency fits the band of the stored code: code 00 for 32..48, code 01 for 49..80, code 11 for 81..120 (integer MHz, inclusive).
- R10: Range code 10 is reserved, and `vco_mismatch` is 1 whenever it is stored, whatever the frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (4) | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pll_sel | input | 1 | Synthesizer is the selected system clock; blocks writes |
| lock_raw | input | 1 | Unqualified lock indication from the loop |
| osc_mhz | input | OSC_W (8) | Oscillator frequency, integer MHz |
| refdiv | input | REF_W (6) | Reference divider field (divides by value+1) |
| lock_ok | output | 1 | Qualified lock status |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| vco_mismatch | output | 1 | Range code does not suit the computed VCO frequency |

## Verification
The stored word is read back combinationally on every cycle, so a corrupted or wrongly gated word shows on `rdata` in the cycle after the faulty edge. The band decode depends on that same word, so the error also reaches `vco_mismatch` at once. A lock counter that runs off by even one cycle moves the rise of `lock_ok` by that cycle, and the per-cycle comparison with the model catches it. The bench drives windows broken at several points and exactly full windows, and these expose an early or late rise. The frequency arithmetic is checked at the band edges 32, 48, 80 and 120, and one step outside each.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int DATA_W = 8;
    localparam int MULT_W = 6;
    localparam int BAND_W = 2;

    localparam int VCO_MIN_MHZ = 32;
    localparam int LO_TOP_MHZ  = 48;
    localparam int MID_TOP_MHZ = 80;
    localparam int VCO_MAX_MHZ = 120;

    typedef enum logic [BAND_W-1:0] {
        BAND_LO   = 2'b00,
        BAND_MID  = 2'b01,
        BAND_RSVD = 2'b10,
        BAND_HI   = 2'b11
    } vco_band_e;

    typedef struct packed {
        vco_band_e           band;
        logic [MULT_W-1:0]   mult;
    } synth_cfg_t;

    function automatic logic band_fits(vco_band_e b, logic [31:0] f);
        case (b)
            BAND_LO:  return (f >= 32'(VCO_MIN_MHZ)) && (f <= 32'(LO_TOP_MHZ));
            BAND_MID: return (f >  32'(LO_TOP_MHZ))  && (f <= 32'(MID_TOP_MHZ));
            BAND_HI:  return (f >  32'(MID_TOP_MHZ)) && (f <= 32'(VCO_MAX_MHZ));
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pllcfg_regfile.sv
module pllcfg_regfile
    import pllcfg_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int REG_OFS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pll_sel,
    output synth_cfg_t        cfg,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_accept,
    output logic              wr_err
);

    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

    logic       hit;
    logic       wr_reject;
    synth_cfg_t cfg_q;

    always_comb begin
        hit       = (addr == OFS);
        wr_accept = wr_en && hit && !pll_sel;
        wr_reject = wr_en && hit && pll_sel;
        rdata     = hit ? cfg_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_reject;
            if (wr_accept) begin
                cfg_q <= synth_cfg_t'(wdata);
            end
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pllcfg_lockqual.sv
module pllcfg_lockqual #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic lock_raw,
    output logic lock_ok
);

    localparam int CNT_W = (LOCK_CYC > 2) ? $clog2(LOCK_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYC - 1);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !lock_raw) begin
            run_q   <= '0;
            lock_ok <= 1'b0;
        end else if (run_q == LAST) begin
            lock_ok <= 1'b1;
        end else begin
            run_q <= run_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pllcfg_vcochk.sv
module pllcfg_vcochk
    import pllcfg_pkg::*;
#(
    parameter int OSC_W = 8,
    parameter int REF_W = 6
) (
    input  synth_cfg_t       cfg,
    input  logic [OSC_W-1:0] osc_mhz,
    input  logic [REF_W-1:0] refdiv,
    output logic             mismatch
);

    localparam int PROD_W = OSC_W + MULT_W + 2;

    logic [PROD_W-1:0] osc_x;
    logic [PROD_W-1:0] mul_x;
    logic [PROD_W-1:0] den_x;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] fvco;

    always_comb begin
        osc_x    = PROD_W'(osc_mhz);
        mul_x    = PROD_W'(cfg.mult) + PROD_W'(1);
        den_x    = PROD_W'(refdiv) + PROD_W'(1);
        prod     = (osc_x * mul_x) << 1;
        fvco     = prod / den_x;
        mismatch = !band_fits(cfg.band, 32'(fvco));
    end

endmodule

// File: rtl/pllcfg_top.sv
module pllcfg_top
    import pllcfg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int OSC_W    = 8,
    parameter int REF_W    = 6,
    parameter int LOCK_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              pll_sel,
    input  logic              lock_raw,
    input  logic [OSC_W-1:0]  osc_mhz,
    input  logic [REF_W-1:0]  refdiv,
    output logic              lock_ok,
    output logic              wr_err,
    output logic              vco_mismatch
);

    synth_cfg_t        cfg_bits;
    logic              wr_accept;

    pllcfg_regfile #(
        .ADDR_W  (ADDR_W),
        .REG_OFS (0)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .pll_sel   (pll_sel),
        .cfg       (cfg_bits),
        .rdata     (rdata),
        .wr_accept (wr_accept),
        .wr_err    (wr_err)
    );

    pllcfg_lockqual #(
        .LOCK_CYC (LOCK_CYC)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_accept),
        .lock_raw (lock_raw),
        .lock_ok  (lock_ok)
    );

    pllcfg_vcochk #(
        .OSC_W (OSC_W),
        .REF_W (REF_W)
    ) u_chk (
        .cfg      (cfg_bits),
        .osc_mhz  (osc_mhz),
        .refdiv   (refdiv),
        .mismatch (vco_mismatch)
    );

endmodule

// File: rtl/pllcfg_sva.sv
module pllcfg_sva #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wdata,
    input logic              pll_sel,
    input logic              lock_raw,
    input logic              lock_ok,
    input logic              wr_err,
    input logic              vco_mismatch,
    input logic [7:0]        cfg_bits
);

    logic at_ofs;
    assign at_ofs = (addr == '0);

    // R3
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && at_ofs && !pll_sel) |=> (cfg_bits == $past(wdata)));

    // R4
    a_r4_refused_keeps_word: assert property (@(posedge clk) disable iff (rst)
        (wr_en && at_ofs && pll_sel) |=> $stable(cfg_bits));

    // R5
    a_r5_err_has_cause: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en && at_ofs && pll_sel));

    // R6
    a_r6_write_drops_lock: assert property (@(posedge clk) disable iff (rst)
        (wr_en && at_ofs && !pll_sel) |=> !lock_ok);

    // R7
    a_r7_rise_needs_raw: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_ok) |-> $past(lock_raw));

    // R7
    a_r7_low_drops_lock: assert property (@(posedge clk) disable iff (rst)
        !lock_raw |=> !lock_ok);

    // R10
    a_r10_reserved_flagged: assert property (@(posedge clk) disable iff (rst)
        (cfg_bits[7:6] == 2'b10) |-> vco_mismatch);

endmodule

bind pllcfg_top pllcfg_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .pll_sel      (pll_sel),
    .lock_raw     (lock_raw),
    .lock_ok      (lock_ok),
    .wr_err       (wr_err),
    .vco_mismatch (vco_mismatch),
    .cfg_bits     (cfg_bits)
);

// File: tb/tb_pllcfg_top.sv
module tb_pllcfg_top;

    localparam int CLK_PERIOD = 10;
    localparam int LOCKN      = 16;
    localparam int WDOG       = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pll_sel = 1'b0;
    logic       lock_raw = 1'b0;
    logic [7:0] osc_mhz = 8'd8;
    logic [5:0] refdiv = '0;
    logic       lock_ok;
    logic       wr_err;
    logic       vco_mismatch;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit running = 0;

    int m_reg = 0;
    int m_cnt = 0;
    bit m_lock = 0;
    bit m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pllcfg_top dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pll_sel(pll_sel), .lock_raw(lock_raw),
        .osc_mhz(osc_mhz), .refdiv(refdiv), .lock_ok(lock_ok),
        .wr_err(wr_err), .vco_mismatch(vco_mismatch)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_reg = 0; m_cnt = 0; m_lock = 0; m_err = 0;
        end else begin
            m_err = wr_en && (addr == 0) && pll_sel;
            if (wr_en && addr == 0 && !pll_sel) begin
                m_reg = int'(wdata);
                m_cnt = 0; m_lock = 0;
            end else if (!lock_raw) begin
                m_cnt = 0; m_lock = 0;
            end else if (m_cnt == LOCKN - 1) begin
                m_lock = 1;
            end else begin
                m_cnt++;
            end
        end
        if (cycles == WDOG) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit exp_mismatch(int word, int osc, int rd);
        int f;
        int band;
        f = (2 * osc * ((word & 63) + 1)) / (rd + 1);
        band = (word >> 6) & 3;
        case (band)
            0: return !(f >= 32 && f <= 48);
            1: return !(f > 48 && f <= 80);
            3: return !(f > 80 && f <= 120);
            default: return 1;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            int er;
            er = (addr == 0) ? m_reg : 0;
            chk(int'(rdata) == er, "R2 R3 R4 rdata", int'(rdata), er);
            chk(lock_ok == m_lock, "R6 R7 lock_ok", int'(lock_ok), int'(m_lock));
            chk(wr_err == m_err, "R5 wr_err", int'(wr_err), int'(m_err));
            chk(vco_mismatch == exp_mismatch(m_reg, int'(osc_mhz), int'(refdiv)),
                "R8 R9 R10 vco_mismatch", int'(vco_mismatch),
                int'(exp_mismatch(m_reg, int'(osc_mhz), int'(refdiv))));
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = '0;
    endtask

    task automatic setf(logic [7:0] o, logic [5:0] r);
        @(posedge clk); #1;
        osc_mhz = o; refdiv = r;
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rdata == 8'h00 && !lock_ok && !wr_err, "R1 reset",
            int'({rdata, lock_ok, wr_err}), 0);
        running = 1;
        lock_raw = 1'b1;
        idle(20);
        // band checks with f = 96
        wr(4'd0, 8'h05);
        wr(4'd0, 8'hC5);
        idle(20);
        // refused writes, single and back to back (R4 R5)
        @(posedge clk); #1; pll_sel = 1'b1;
        wr(4'd0, 8'h00);
        @(posedge clk); #1;
        addr = 4'd0; wdata = 8'h3F; wr_en = 1'b1;
        idle(2);
        wr_en = 1'b0;
        idle(3);
        @(posedge clk); #1; pll_sel = 1'b0;
        // boundaries at 48
        wr(4'd0, 8'h42);
        wr(4'd0, 8'h02);
        // reserved code (R10)
        wr(4'd0, 8'h81);
        idle(3);
        // broken lock windows (R7)
        wr(4'd0, 8'hC5);
        idle(10);
        @(posedge clk); #1; lock_raw = 1'b0;
        @(posedge clk); #1; lock_raw = 1'b1;
        idle(15);
        @(posedge clk); #1; lock_raw = 1'b0;
        @(posedge clk); #1; lock_raw = 1'b1;
        idle(18);
        // other address: ignored, reads zero (R2 R4)
        wr(4'd3, 8'hAA);
        @(posedge clk); #1; addr = 4'd3;
        idle(2);
        addr = 4'd0;
        idle(2);
        // R8 edges: 32, 31, 120, 121, 80, 81
        wr(4'd0, 8'h00);
        setf(8'd16, 6'd0); idle(1);
        setf(8'd31, 6'd1); idle(1);
        wr(4'd0, 8'hC0);
        setf(8'd60, 6'd0); idle(1);
        setf(8'd121, 6'd1); idle(1);
        setf(8'd81, 6'd1); idle(1);
        wr(4'd0, 8'h40);
        setf(8'd40, 6'd0); idle(1);
        setf(8'd81, 6'd1); idle(1);
        // sweep multiplier for each band
        for (int b = 0; b < 4; b++) begin
            setf(8'd10, 6'd3);
            for (int m = 0; m < 64; m += 3) begin
                wr(4'd0, 8'((b << 6) | m));
            end
        end
        idle(20);
        running = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule